// File: doc/BRIEF.md
# In-band Loop Code Detector

This block watches a serial E1 receive stream for two repeating in-band loopback codes, one that asks the far end to close a line loop (actuate) and one that asks it to open the loop again (deactuate). Each code is a programmable pattern of 1 to 8 bits. Each detector compares every counted receive bit with the pattern bit it expects next, and it counts the mismatches over fixed windows of counted bits.

A status flag rises only after the code has been present for a long qualification span with a low error ratio. It stays up while every later window keeps the error ratio low, and it drops on the first window that has too many errors. On a bad window the detector also slides its pattern position to the rotation that best fits the most recent bits, so that a code arriving at any phase is picked up. When the framing-aligned input is high, timeslot-0 bits carry framing rather than payload and play no part. Any change of either flag produces a one-cycle interrupt pulse.

With default parameters a window is 1000 counted bits, more than 10 mismatches in a window marks it bad, and qualification needs 51,200 counted bits, which is 25 ms at 2.048 Mbit/s.

Top module: `loop_code_det`

## Requirements
- R1: While rst_n is low, and after it is released, act_det, dea_det and chg_irq are low, and the reset itself causes no interrupt pulse.
- R2: The two detectors are independent: act_det follows only act_pat/act_len and dea_det follows only dea_pat/dea_len.
- R3: A pattern is sent bit 0 first, then bit 1, up to bit len-1, and then it repeats. A length of 0 acts as 1 and a length above PAT_MAX acts as PAT_MAX.
- R4: A counted bit is a cycle with bit_vld high, except when frm_aligned and ts0 are both high. Only counted bits are compared, advance the pattern position, fill a window and run the qualification timer.
- R5: Windows are consecutive runs of WIN_BITS counted bits that start at reset. A window is bad when its mismatch count exceeds ERR_MAX.
- R6: A flag rises in the cycle after the counted bit that closes a good window, provided at least QUAL_BITS counted bits (that bit included) have passed since the last bad window or since reset.
- R7: A set flag stays set through good windows. A bad window clears the flag and restarts the qualification timer from zero.
- R8: With frm_aligned low, bits marked ts0 are counted like any other bit.
- R9: chg_irq is high for exactly the cycles in which act_det or dea_det differs from its value in the previous cycle, for both rising and falling changes.
- R10: At the close of a bad window, the next expected position becomes the rotation q that gives the fewest mismatches when the last len counted bits (oldest first) are compared against pattern positions q, q+1, ... modulo len. On a tie the lowest q wins.
- R11: A cycle with bit_vld low changes neither flag and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe marking a cycle that carries a receive bit |
| rx_bit | input | 1 | Receive data bit |
| frm_aligned | input | 1 | Framing is aligned; timeslot-0 bits are then excluded |
| ts0 | input | 1 | Current bit lies in timeslot 0 |
| act_pat | input | PAT_MAX | Actuate code pattern, bit 0 sent first |
| act_len | input | clog2(PAT_MAX+1) | Actuate code length |
| dea_pat | input | PAT_MAX | Deactuate code pattern, bit 0 sent first |
| dea_len | input | clog2(PAT_MAX+1) | Deactuate code length |
| act_det | output | 1 | Actuate code detected |
| dea_det | output | 1 | Deactuate code detected |
| chg_irq | output | 1 | One-cycle pulse on any flag change |

## Verification
The bench builds the block with QUAL_BITS=60, WIN_BITS=20 and ERR_MAX=2 instead of 51,200, 1000 and 10. With these values a flag can rise, fall and rise again many times within a few thousand cycles, and random single-bit errors push windows back and forth across the error limit often. A frame of 16 bits with four timeslot-0 positions makes every window, aligned or not, contain excluded or corrupted timeslot-0 bits. That brings the exclusion rule, the restart of the qualification timer and the re-phasing after a shifted code within reach of a short run.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic {
    CH_ACT = 1'b0,
    CH_DEA = 1'b1
  } lcd_ch_e;

  localparam int LCD_NUM_CH = 2;
endpackage

// File: rtl/lcd_win.sv
module lcd_win #(
  parameter int WIN_BITS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  output logic last_o
);
  localparam int WW = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;

  logic [WW-1:0] pos_q, pos_d;

  assign last_o = (pos_q == WW'(WIN_BITS - 1));

  always_comb begin
    pos_d = pos_q;
    if (cnt_en) begin
      pos_d = last_o ? '0 : pos_q + WW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/lcd_phase.sv
module lcd_phase #(
  parameter int PAT_MAX = 8,
  localparam int LW = $clog2(PAT_MAX + 1),
  localparam int PW = (PAT_MAX > 1) ? $clog2(PAT_MAX) : 1
) (
  input  logic [PAT_MAX-1:0] hist_i,
  input  logic [PAT_MAX-1:0] pat_i,
  input  logic [LW-1:0]      len_i,
  output logic [PW-1:0]      phase_o
);
  localparam int CW = $clog2(PAT_MAX + 2);

  logic [CW-1:0] cnt, best_cnt;
  logic [PW-1:0] hi, pi;
  int            ln, idx;

  always_comb begin
    ln       = int'(len_i);
    best_cnt = '1;
    phase_o  = '0;
    cnt      = '0;
    hi       = '0;
    pi       = '0;
    idx      = 0;
    for (int q = 0; q < PAT_MAX; q++) begin
      if (q < ln) begin
        cnt = '0;
        for (int j = 0; j < PAT_MAX; j++) begin
          if (j < ln) begin
            idx = q + j;
            if (idx >= ln) idx = idx - ln;
            hi = PW'(ln - 1 - j);
            pi = PW'(idx);
            if (hist_i[hi] != pat_i[pi]) cnt = cnt + CW'(1);
          end
        end
        if (cnt < best_cnt) begin
          best_cnt = cnt;
          phase_o  = PW'(q);
        end
      end
    end
  end
endmodule

// File: rtl/lcd_chan.sv
module lcd_chan #(
  parameter int PAT_MAX   = 8,
  parameter int QUAL_BITS = 51200,
  parameter int WIN_BITS  = 1000,
  parameter int ERR_MAX   = 10,
  localparam int LW = $clog2(PAT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic               win_last,
  input  logic               rx_bit,
  input  logic [PAT_MAX-1:0] pat_i,
  input  logic [LW-1:0]      len_i,
  output logic               det_q,
  output logic               det_d
);
  localparam int PW = (PAT_MAX > 1) ? $clog2(PAT_MAX) : 1;
  localparam int QW = $clog2(QUAL_BITS + 1);
  localparam int EW = $clog2(WIN_BITS + 2);

  logic [PW-1:0]      ptr_q, ptr_d, ptr_inc, best;
  logic [PAT_MAX-1:0] hist_q, hist_d;
  logic [QW-1:0]      qual_q, qual_d, qual_sat;
  logic [EW-1:0]      err_q, err_d, err_tot;
  logic [LW-1:0]      len_eff;
  logic               mis, bad;

  always_comb begin
    if (len_i == '0)                    len_eff = LW'(1);
    else if (len_i > LW'(PAT_MAX))      len_eff = LW'(PAT_MAX);
    else                                len_eff = len_i;
  end

  assign mis      = cnt_en && (rx_bit != pat_i[ptr_q]);
  assign err_tot  = err_q + EW'(mis);
  assign bad      = win_last && (err_tot > EW'(ERR_MAX));
  assign qual_sat = (qual_q == QW'(QUAL_BITS)) ? qual_q : qual_q + QW'(1);
  assign ptr_inc  = ((LW'(ptr_q) + LW'(1)) >= len_eff) ? '0 : ptr_q + PW'(1);

  generate
    if (PAT_MAX > 1) begin : g_hist
      assign hist_d = cnt_en ? {hist_q[PAT_MAX-2:0], rx_bit} : hist_q;
    end else begin : g_hist1
      assign hist_d = cnt_en ? rx_bit : hist_q;
    end
  endgenerate

  lcd_phase #(.PAT_MAX(PAT_MAX)) u_phase (
    .hist_i (hist_d),
    .pat_i  (pat_i),
    .len_i  (len_eff),
    .phase_o(best)
  );

  always_comb begin
    ptr_d  = ptr_q;
    qual_d = qual_q;
    err_d  = err_q;
    det_d  = det_q;
    if (cnt_en) begin
      if (win_last) begin
        err_d = '0;
        if (bad) begin
          ptr_d  = best;
          qual_d = '0;
          det_d  = 1'b0;
        end else begin
          ptr_d  = ptr_inc;
          qual_d = qual_sat;
          if (qual_sat >= QW'(QUAL_BITS)) det_d = 1'b1;
        end
      end else begin
        err_d  = err_tot;
        ptr_d  = ptr_inc;
        qual_d = qual_sat;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      hist_q <= '0;
      qual_q <= '0;
      err_q  <= '0;
      det_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      hist_q <= hist_d;
      qual_q <= qual_d;
      err_q  <= err_d;
      det_q  <= det_d;
    end
  end
endmodule

// File: rtl/loop_code_det.sv
module loop_code_det #(
  parameter int PAT_MAX   = 8,
  parameter int QUAL_BITS = 51200,
  parameter int WIN_BITS  = 1000,
  parameter int ERR_MAX   = 10,
  localparam int LW = $clog2(PAT_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_vld,
  input  logic               rx_bit,
  input  logic               frm_aligned,
  input  logic               ts0,
  input  logic [PAT_MAX-1:0] act_pat,
  input  logic [LW-1:0]      act_len,
  input  logic [PAT_MAX-1:0] dea_pat,
  input  logic [LW-1:0]      dea_len,
  output logic               act_det,
  output logic               dea_det,
  output logic               chg_irq
);
  import lcd_pkg::*;

  logic                          cnt_en, win_last, irq_d, irq_q;
  logic [PAT_MAX-1:0]            pat_a [LCD_NUM_CH];
  logic [LW-1:0]                 len_a [LCD_NUM_CH];
  logic [LCD_NUM_CH-1:0]         det_q, det_d;

  assign cnt_en = bit_vld && !(frm_aligned && ts0);

  assign pat_a[CH_ACT] = act_pat;
  assign pat_a[CH_DEA] = dea_pat;
  assign len_a[CH_ACT] = act_len;
  assign len_a[CH_DEA] = dea_len;

  lcd_win #(.WIN_BITS(WIN_BITS)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .last_o (win_last)
  );

  generate
    for (genvar g = 0; g < LCD_NUM_CH; g++) begin : g_ch
      lcd_chan #(
        .PAT_MAX  (PAT_MAX),
        .QUAL_BITS(QUAL_BITS),
        .WIN_BITS (WIN_BITS),
        .ERR_MAX  (ERR_MAX)
      ) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .win_last(win_last),
        .rx_bit  (rx_bit),
        .pat_i   (pat_a[g]),
        .len_i   (len_a[g]),
        .det_q   (det_q[g]),
        .det_d   (det_d[g])
      );
    end
  endgenerate

  assign irq_d = |(det_d ^ det_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign act_det = det_q[CH_ACT];
  assign dea_det = det_q[CH_DEA];
  assign chg_irq = irq_q;
endmodule

// File: rtl/lcd_chk.sv
module lcd_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic frm_aligned,
  input logic ts0,
  input logic act_det,
  input logic dea_det,
  input logic chg_irq
);
  // R9
  irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_det != $past(act_det)) || (dea_det != $past(dea_det))) |-> chg_irq);

  // R9
  irq_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_irq |-> ((act_det != $past(act_det)) || (dea_det != $past(dea_det))));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> ($stable(act_det) && $stable(dea_det) && !chg_irq));

  // R4
  ts0_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && frm_aligned && ts0) |=> ($stable(act_det) && $stable(dea_det)));

  // R6
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_det) |-> $past(bit_vld));

  // R6
  dea_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dea_det) |-> $past(bit_vld));
endmodule

bind loop_code_det lcd_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_vld    (bit_vld),
  .frm_aligned(frm_aligned),
  .ts0        (ts0),
  .act_det    (act_det),
  .dea_det    (dea_det),
  .chg_irq    (chg_irq)
);

// File: tb/sim_loop_code_det.sv
`timescale 1ns/1ps
module sim_loop_code_det;
  localparam int QB = 60, WB = 20, EM = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0, rx_bit = 1'b0, frm_aligned = 1'b0, ts0 = 1'b0;
  logic [7:0] act_pat = 8'b0001_0110;
  logic [3:0] act_len = 4'd5;
  logic [7:0] dea_pat = 8'h00;
  logic [3:0] dea_len = 4'd8;
  logic act_det, dea_det, chg_irq;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int m_ptr[2], m_err[2], m_qual[2], m_win;
  logic [7:0] m_hist[2];
  logic m_det[2], m_irq;
  int src = 0, fp = 0;

  always #2.5 clk = ~clk;

  loop_code_det #(.PAT_MAX(8), .QUAL_BITS(QB), .WIN_BITS(WB), .ERR_MAX(EM)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .frm_aligned(frm_aligned), .ts0(ts0), .act_pat(act_pat), .act_len(act_len),
    .dea_pat(dea_pat), .dea_len(dea_len), .act_det(act_det), .dea_det(dea_det),
    .chg_irq(chg_irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R10: lowest rotation with fewest mismatches over last len bits
  function automatic int best_rot(logic [7:0] h, logic [7:0] p, int ln);
    int bq = 0, bc = 99;
    for (int q = 0; q < ln; q++) begin
      int c = 0;
      for (int j = 0; j < ln; j++) begin
        int k = (q + j) % ln;
        if (h[ln-1-j] != p[k]) c++;
      end
      if (c < bc) begin bc = c; bq = q; end
    end
    return bq;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_ptr[c] = 0; m_err[c] = 0; m_qual[c] = 0; m_hist[c] = '0; m_det[c] = 0;
    end
    m_win = 0; m_irq = 0;
  endtask

  task automatic model_step(bit v, bit b, bit al, bit t0);
    bit cnt = v && !(al && t0);
    bit last = (m_win == WB - 1);
    logic old0 = m_det[0], old1 = m_det[1];
    if (cnt) begin
      for (int c = 0; c < 2; c++) begin
        logic [7:0] p = (c == 0) ? act_pat : dea_pat;
        int ln = (c == 0) ? int'(act_len) : int'(dea_len);
        int et = m_err[c] + ((b != p[m_ptr[c]]) ? 1 : 0);
        int qs = (m_qual[c] >= QB) ? QB : m_qual[c] + 1;
        int pi = (m_ptr[c] + 1 >= ln) ? 0 : m_ptr[c] + 1;
        m_hist[c] = {m_hist[c][6:0], b};
        if (last) begin
          m_err[c] = 0;
          if (et > EM) begin
            m_ptr[c] = best_rot(m_hist[c], p, ln); m_qual[c] = 0; m_det[c] = 0;
          end else begin
            m_ptr[c] = pi; m_qual[c] = qs;
            if (qs >= QB) m_det[c] = 1;
          end
        end else begin
          m_err[c] = et; m_ptr[c] = pi; m_qual[c] = qs;
        end
      end
      m_win = last ? 0 : m_win + 1;
    end
    m_irq = (old0 != m_det[0]) || (old1 != m_det[1]);
  endtask

  // one cycle: compare, then drive
  task automatic cyc(bit v, bit b, bit al, bit t0);
    @(negedge clk);
    // R6 R7 R9 R10 R2 R5
    check(act_det === m_det[0], "R6/R7 act_det", act_det, m_det[0]);
    check(dea_det === m_det[1], "R2 dea_det", dea_det, m_det[1]);
    check(chg_irq === m_irq, "R9 chg_irq", chg_irq, m_irq);
    bit_vld = v; rx_bit = b; frm_aligned = al; ts0 = t0;
    model_step(v, b, al, t0);
  endtask

  // kind: 0 actuate code, 1 zeros, 2 random
  task automatic run(int n, bit al, int vperc, int kind, int flip, bit ts0_inv);
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom % 100) < vperc;
      bit t0 = (fp < 4);
      bit b = $urandom % 2;
      if (v) begin
        if (!(al && t0)) begin
          if (kind == 0) begin b = act_pat[src]; src = (src + 1) % 5; end
          else if (kind == 1) b = 1'b0;
          if (!al && t0 && ts0_inv) b = ~b;
          if (($urandom % 1000) < flip) b = ~b;
        end
        fp = (fp + 1) % 16;
      end
      cyc(v, b, al, t0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic sa, sd;
    bit irq_seen;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(act_det === 1'b0 && dea_det === 1'b0 && chg_irq === 1'b0, "R1 reset", act_det, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 1, 0);
      check(chg_irq === 1'b0, "R1 no irq after release", chg_irq, 0);
    end

    // R3 R4 R6: aligned clean actuate code, ts0 bits random and excluded
    run(400, 1, 100, 0, 0, 0);
    check(act_det === 1'b1, "R6 act set on clean code", act_det, 1);
    check(dea_det === 1'b0, "R2 dea stays low", dea_det, 0);

    // R8 R7: unaligned, ts0 bits corrupted, now counted
    run(150, 0, 100, 0, 0, 1);
    check(act_det === 1'b0, "R8 unaligned ts0 errors clear act", act_det, 0);

    // R10 R11: shifted code, sparse strobe
    src = (src + 2) % 5;
    run(500, 1, 70, 0, 0, 0);
    check(act_det === 1'b1, "R10 re-phase then detect", act_det, 1);

    // R2: zeros match only the deactuate code
    run(400, 1, 100, 1, 0, 0);
    check(dea_det === 1'b1, "R2 dea set on its code", dea_det, 1);
    check(act_det === 1'b0, "R2 act cleared", act_det, 0);

    // R5 R7: code with random errors near the limit
    run(2000, 1, 90, 1, 60, 0);
    run(1500, 1, 90, 0, 40, 0);

    // R11: no strobe
    sa = act_det; sd = dea_det; irq_seen = 0;
    for (int i = 0; i < 50; i++) begin
      cyc(0, $urandom % 2, $urandom % 2, $urandom % 2);
      if (chg_irq) irq_seen = 1;
    end
    check(act_det === sa && dea_det === sd, "R11 flags held without strobe", act_det, sa);
    check(!irq_seen, "R11 no irq without strobe", irq_seen, 0);

    // random data
    run(500, 0, 80, 2, 0, 0);

    // R1: mid-run reset after deactuate detected
    run(300, 1, 100, 1, 0, 0);
    check(dea_det === 1'b1, "R1 pre-reset dea set", dea_det, 1);
    @(negedge clk);
    rst_n = 1'b0; bit_vld = 0;
    model_reset();
    @(negedge clk);
    check(act_det === 1'b0 && dea_det === 1'b0, "R1 flags cleared by reset", dea_det, 0);
    check(chg_irq === 1'b0, "R1 no irq from reset", chg_irq, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0);
    check(chg_irq === 1'b0 && dea_det === 1'b0, "R1 quiet after reset", chg_irq, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule